// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block decides when the receive side of a host-attached bus controller interrupts the host. Each message that the data mover has placed in host memory is signalled by a one-cycle strobe; the block keeps a pending count of such messages and, once armed, produces a 32-bit status word together with a one-cycle write strobe. It raises the interrupt when the pending count reaches a programmed limit, when a programmed time has passed since messages became pending, or when a transmit-link event has been reported. The status word is meant to be written at the head of the host's receive area.

Interrupts are handed out one batch at a time. After a batch is reported, the block stays silent and keeps counting new messages until the host writes the next value of a 4-bit rolling tag. Several channels can therefore share one interrupt line: each handler compares the tag in its status word with the tag it last wrote. A control register with separate set and clear ports holds an engine-hold bit and an interrupt-enable bit. A limits register sets the count limit and the time limit. The time limit is counted in 100 µs ticks, which a prescaler derives from the system clock.

Top module: `rx_irq_coalesce`

## Requirements
- R1: After reset the engine-hold bit is 1, the interrupt enable is 0, the count limit is 16, the time limit is 10, irq and status_wr are 0, status_word is 0, the stored tag is 0 and the engine is not armed.
- R2: Register select 0 sets and select 1 clears control bits; bit 17 is engine hold and bit 18 is interrupt enable. Other bits written to these ports have no effect.
- R3: While engine hold is 1, no status word is written, the pending count, link flag and timer are discarded, the engine is disarmed and the irq line falls on the next cycle.
- R4: A write to register select 3 re-arms the engine only if the engine is disarmed, not held, and data bits 3:0 equal the stored tag plus one modulo 16. That value then becomes the stored tag. Any other acknowledge write is ignored.
- R5: While armed with a nonzero pending count that is at least the count limit, the block pulses status_wr for one cycle on the next clock edge and then disarms.
- R6: A tick occurs every TICK_DIV clocks counted from reset. While armed with a nonzero pending count, a timer counts ticks (saturating at 255) and a report fires once the timer is at least the time limit. The timer is zero while disarmed or while the pending count is zero, and it is cleared by a report.
- R7: Status word layout: bits 3:0 hold the stored tag, bits 10:4 hold the pending count being reported, bit 16 is the link flag, and all other bits are 0. The word holds its value between reports.
- R8: Messages posted while disarmed, including one posted in the cycle of a report, accumulate in the pending count and are reported after the next accepted acknowledge.
- R9: A transmit-link event makes an armed engine report even with zero pending messages; the report then carries a count of 0 and bit 16 set.
- R10: irq is 1 exactly while a report has been made and not yet acknowledged and the interrupt enable is 1.
- R11: Register select 2 loads the count limit from data bits 7:0 and the time limit from bits 15:8.
- R12: The pending count saturates at 127.
- R13: The stored tag wraps from 15 to 0 on acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_posted | input | 1 | One-cycle strobe: one message placed in host memory |
| link_event | input | 1 | One-cycle strobe: transmit-link event |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control set, 1 control clear, 2 limits, 3 acknowledge |
| cfg_wdata | input | 32 | Register write data |
| status_word | output | 32 | Status word for the head of the receive area |
| status_wr | output | 1 | One-cycle strobe: status_word is new |
| irq | output | 1 | Interrupt request line |

## Verification
The bench builds the block with a 20-clock prescaler instead of the 12500-clock default. Timeouts of a few ticks then finish within about a hundred cycles, and a full 255-tick saturated timeout fits in the run. With this short tick, one run covers timeout reports, the 127 saturation of the count field, a full wrap of the rolling tag through sixteen acknowledges, and reports that fire while the interrupt enable is off.

// File: rtl/rxic_pkg.sv
package rxic_pkg;
    localparam int TAG_W    = 4;
    localparam int CNT_W    = 7;
    localparam int LIM_W    = 8;
    localparam int WORD_W   = 32;
    localparam int TAG_LSB  = 0;
    localparam int CNT_LSB  = 4;
    localparam int LINK_BIT = 16;
    localparam int HOLD_BIT = 17;
    localparam int IEN_BIT  = 18;

    typedef enum logic [1:0] {
        SEL_CTRL_SET = 2'd0,
        SEL_CTRL_CLR = 2'd1,
        SEL_LIMITS   = 2'd2,
        SEL_ACK      = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             hold;
        logic             ien;
        logic [LIM_W-1:0] cnt_lim;
        logic [LIM_W-1:0] time_lim;
    } regs_s;

    typedef struct packed {
        logic              armed;
        logic [TAG_W-1:0]  tag;
        logic [CNT_W-1:0]  pend;
        logic              link;
        logic [LIM_W-1:0]  tmo;
        logic              irqp;
        logic              stwr;
        logic [WORD_W-1:0] stat;
    } core_s;
endpackage

// File: rtl/rxic_tick.sv
module rxic_tick #(
    parameter int TICK_DIV = 12500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rxic_regs.sv
module rxic_regs
    import rxic_pkg::*;
#(
    parameter int DEF_CNT_LIM  = 16,
    parameter int DEF_TIME_LIM = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              hold,
    output logic              ien,
    output logic [LIM_W-1:0]  cnt_lim,
    output logic [LIM_W-1:0]  time_lim,
    output logic              ack_wr,
    output logic [TAG_W-1:0]  ack_tag
);
    regs_s r_d, r_q;
    reg_sel_e sel;
    logic unused_wdata;

    assign sel          = reg_sel_e'(cfg_sel);
    assign unused_wdata = ^{cfg_wdata[WORD_W-1:IEN_BIT+1], cfg_wdata[LINK_BIT]};

    always_comb begin
        r_d = r_q;
        if (cfg_wr) begin
            case (sel)
                SEL_CTRL_SET: begin
                    if (cfg_wdata[HOLD_BIT]) r_d.hold = 1'b1;
                    if (cfg_wdata[IEN_BIT])  r_d.ien  = 1'b1;
                end
                SEL_CTRL_CLR: begin
                    if (cfg_wdata[HOLD_BIT]) r_d.hold = 1'b0;
                    if (cfg_wdata[IEN_BIT])  r_d.ien  = 1'b0;
                end
                SEL_LIMITS: begin
                    r_d.cnt_lim  = cfg_wdata[LIM_W-1:0];
                    r_d.time_lim = cfg_wdata[2*LIM_W-1:LIM_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.hold     <= 1'b1;
            r_q.ien      <= 1'b0;
            r_q.cnt_lim  <= LIM_W'(DEF_CNT_LIM);
            r_q.time_lim <= LIM_W'(DEF_TIME_LIM);
        end else begin
            r_q <= r_d;
        end
    end

    assign hold     = r_q.hold;
    assign ien      = r_q.ien;
    assign cnt_lim  = r_q.cnt_lim;
    assign time_lim = r_q.time_lim;
    assign ack_wr   = cfg_wr && (sel == SEL_ACK);
    assign ack_tag  = cfg_wdata[TAG_LSB +: TAG_W];
endmodule

// File: rtl/rxic_core.sv
module rxic_core
    import rxic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold,
    input  logic              ien,
    input  logic [LIM_W-1:0]  cnt_lim,
    input  logic [LIM_W-1:0]  time_lim,
    input  logic              ack_wr,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic              msg_posted,
    input  logic              link_event,
    output logic [WORD_W-1:0] status_word,
    output logic              status_wr,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [LIM_W-1:0] TMO_MAX = '1;

    core_s c_d, c_q;
    logic  fire;
    logic  ack_ok;
    logic  has_pend;

    always_comb begin
        has_pend = (c_q.pend != '0);
        fire     = c_q.armed &&
                   (c_q.link ||
                    (has_pend && (({1'b0, c_q.pend} >= cnt_lim) || (c_q.tmo >= time_lim))));
        ack_ok   = ack_wr && !c_q.armed && (ack_tag == TAG_W'(c_q.tag + 1'b1));

        c_d      = c_q;
        c_d.stwr = 1'b0;
        if (hold) begin
            c_d.armed = 1'b0;
            c_d.pend  = '0;
            c_d.link  = 1'b0;
            c_d.tmo   = '0;
            c_d.irqp  = 1'b0;
        end else if (fire) begin
            c_d.stwr                     = 1'b1;
            c_d.stat                     = '0;
            c_d.stat[TAG_LSB +: TAG_W]   = c_q.tag;
            c_d.stat[CNT_LSB +: CNT_W]   = c_q.pend;
            c_d.stat[LINK_BIT]           = c_q.link;
            c_d.pend                     = msg_posted ? CNT_W'(1) : '0;
            c_d.link                     = link_event;
            c_d.tmo                      = '0;
            c_d.armed                    = 1'b0;
            c_d.irqp                     = 1'b1;
        end else begin
            if (msg_posted && (c_q.pend != CNT_MAX)) c_d.pend = c_q.pend + 1'b1;
            if (link_event) c_d.link = 1'b1;
            if (c_q.armed && has_pend) begin
                if (tick && (c_q.tmo != TMO_MAX)) c_d.tmo = c_q.tmo + 1'b1;
            end else begin
                c_d.tmo = '0;
            end
            if (ack_ok) begin
                c_d.armed = 1'b1;
                c_d.tag   = ack_tag;
                c_d.irqp  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign status_word = c_q.stat;
    assign status_wr   = c_q.stwr;
    assign irq         = c_q.irqp && ien;
endmodule

// File: rtl/rx_irq_coalesce.sv
module rx_irq_coalesce
    import rxic_pkg::*;
#(
    parameter int TICK_DIV     = 12500,
    parameter int DEF_CNT_LIM  = 16,
    parameter int DEF_TIME_LIM = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msg_posted,
    input  logic        link_event,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] status_word,
    output logic        status_wr,
    output logic        irq
);
    logic             tick;
    logic             eng_hold;
    logic             irq_enable;
    logic [LIM_W-1:0] cnt_lim;
    logic [LIM_W-1:0] time_lim;
    logic             ack_wr;
    logic [TAG_W-1:0] ack_tag;

    rxic_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    rxic_regs #(.DEF_CNT_LIM(DEF_CNT_LIM), .DEF_TIME_LIM(DEF_TIME_LIM)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .hold     (eng_hold),
        .ien      (irq_enable),
        .cnt_lim  (cnt_lim),
        .time_lim (time_lim),
        .ack_wr   (ack_wr),
        .ack_tag  (ack_tag)
    );

    rxic_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hold       (eng_hold),
        .ien        (irq_enable),
        .cnt_lim    (cnt_lim),
        .time_lim   (time_lim),
        .ack_wr     (ack_wr),
        .ack_tag    (ack_tag),
        .msg_posted (msg_posted),
        .link_event (link_event),
        .status_word(status_word),
        .status_wr  (status_wr),
        .irq        (irq)
    );
endmodule

// File: rtl/rx_irq_coalesce_chk.sv
module rx_irq_coalesce_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        status_wr,
    input logic [31:0] status_word,
    input logic        eng_hold,
    input logic        irq_enable
);
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_enable);

    assert_hold_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_hold |=> !status_wr);

    assert_hold_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_hold |=> !irq);

    assert_report_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |-> ((status_word[10:4] != 7'd0) || status_word[16]));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |=> !status_wr);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |-> ((status_word[31:17] == 15'd0) && (status_word[15:11] == 5'd0)));
endmodule

bind rx_irq_coalesce rx_irq_coalesce_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .status_wr  (status_wr),
    .status_word(status_word),
    .eng_hold   (eng_hold),
    .irq_enable (irq_enable)
);

// File: tb/rx_irq_coalesce_tb.sv
module rx_irq_coalesce_tb;
    localparam int TDIV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_posted = 1'b0;
    logic        link_event = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] status_word;
    logic        status_wr;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    int    cur_tag = 0;
    bit    cmp_on = 1'b0;
    string phase = "R1";

    // reference model state
    int m_hold = 1, m_ien = 0, m_cl = 16, m_tl = 10;
    int m_tag = 0, m_armed = 0, m_pend = 0, m_link = 0, m_tmo = 0, m_irqp = 0;
    int m_stwr = 0, m_presc = 0;
    logic [31:0] m_stat = 32'd0;

    always #4 clk = ~clk;

    rx_irq_coalesce #(.TICK_DIV(TDIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .msg_posted(msg_posted), .link_event(link_event),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .status_word(status_word), .status_wr(status_wr), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hold = 1; m_ien = 0; m_cl = 16; m_tl = 10;
            m_tag = 0; m_armed = 0; m_pend = 0; m_link = 0; m_tmo = 0; m_irqp = 0;
            m_stwr = 0; m_presc = 0; m_stat = 32'd0;
        end else begin
            automatic bit tk = (m_presc == TDIV - 1);
            automatic int o_hold = m_hold;
            automatic bit trig = m_armed != 0 &&
                (m_link != 0 || (m_pend > 0 && (m_pend >= m_cl || m_tmo >= m_tl)));
            automatic bit ackok = cfg_wr && cfg_sel == 2'd3 && m_armed == 0 &&
                int'(cfg_wdata[3:0]) == (m_tag + 1) % 16;
            m_presc = tk ? 0 : m_presc + 1;
            m_stwr = 0;
            if (o_hold != 0) begin
                m_armed = 0; m_pend = 0; m_link = 0; m_tmo = 0; m_irqp = 0;
            end else if (trig) begin
                m_stwr = 1;
                m_stat = 32'(m_tag) | (32'(m_pend) << 4) | (32'(m_link) << 16);
                m_pend = msg_posted ? 1 : 0;
                m_link = link_event ? 1 : 0;
                m_tmo = 0; m_armed = 0; m_irqp = 1;
            end else begin
                automatic bit counting = m_armed != 0 && m_pend > 0;
                if (counting) begin
                    if (tk && m_tmo < 255) m_tmo++;
                end else m_tmo = 0;
                if (msg_posted && m_pend < 127) m_pend++;
                if (link_event) m_link = 1;
                if (ackok) begin
                    m_armed = 1; m_tag = int'(cfg_wdata[3:0]); m_irqp = 0;
                end
            end
            if (cfg_wr) begin
                case (cfg_sel)
                    2'd0: begin if (cfg_wdata[17]) m_hold = 1; if (cfg_wdata[18]) m_ien = 1; end
                    2'd1: begin if (cfg_wdata[17]) m_hold = 0; if (cfg_wdata[18]) m_ien = 0; end
                    2'd2: begin m_cl = int'(cfg_wdata[7:0]); m_tl = int'(cfg_wdata[15:8]); end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            automatic logic [31:0] mirq = 32'(m_irqp != 0 && m_ien != 0);
            check(status_word == m_stat, {phase, " status_word"}, status_word, m_stat);
            check(32'(status_wr) == 32'(m_stwr), {phase, " status_wr"}, 32'(status_wr), 32'(m_stwr));
            check(32'(irq) == mirq, {phase, " irq"}, 32'(irq), mirq);
        end
        if (cycles > 100000) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0; cfg_wdata = 32'd0;
    endtask

    task automatic ack_next();
        cur_tag = (cur_tag + 1) % 16;
        wr(2'd3, 32'(cur_tag));
    endtask

    task automatic post(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); msg_posted = 1'b1;
        end
        @(negedge clk); msg_posted = 1'b0;
    endtask

    task automatic pulse_link();
        @(negedge clk); link_event = 1'b1;
        @(negedge clk); link_event = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        phase = "R1";
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(3);
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'd0);
        check(status_word == 32'd0, "R1 status after reset", status_word, 32'd0);
        // hold is set at reset: posted messages produce nothing
        post(20);
        idle(5);
        check(status_wr == 1'b0, "R1 no report while held", 32'(status_wr), 32'd0);

        phase = "R11";
        wr(2'd2, {16'd0, 8'd3, 8'd4});
        phase = "R2";
        wr(2'd1, 32'h0002_0000 | 32'h0001_0000);
        wr(2'd0, 32'h0004_0000);
        phase = "R4";
        ack_next();
        phase = "R5";
        post(4);
        idle(3);
        check(status_word == 32'h41, "R5 R7 count-limit report", status_word, 32'h41);
        check(irq == 1'b1, "R10 irq after report", 32'(irq), 32'd1);

        phase = "R8";
        post(2);
        wr(2'd3, 32'd7);
        idle(30);
        ack_next();
        phase = "R6";
        idle(120);
        check(status_word == 32'h22, "R6 R8 timeout report", status_word, 32'h22);

        phase = "R9";
        ack_next();
        idle(2);
        pulse_link();
        idle(4);
        check(status_word == 32'h0001_0003, "R9 link-only report", status_word, 32'h0001_0003);

        phase = "R10";
        wr(2'd1, 32'h0004_0000);
        ack_next();
        post(4);
        idle(3);
        check(irq == 1'b0, "R10 irq masked", 32'(irq), 32'd0);
        wr(2'd0, 32'h0004_0000);
        idle(2);
        check(irq == 1'b1, "R10 irq unmasked", 32'(irq), 32'd1);

        phase = "R13";
        for (int k = 0; k < 14; k++) begin
            ack_next();
            idle(2);
            pulse_link();
            idle(4);
        end
        check(status_word[3:0] == 4'd2, "R13 tag after wrap", 32'(status_word[3:0]), 32'd2);

        phase = "R12";
        wr(2'd2, {16'd0, 8'd255, 8'd200});
        ack_next();
        post(130);
        idle(5200);
        check(status_word[10:4] == 7'd127, "R12 saturated count", 32'(status_word[10:4]), 32'd127);

        phase = "R3";
        wr(2'd2, {16'd0, 8'd3, 8'd4});
        wr(2'd0, 32'h0002_0000);
        idle(2);
        check(irq == 1'b0, "R3 irq dropped by hold", 32'(irq), 32'd0);
        post(5);
        pulse_link();
        idle(10);
        wr(2'd1, 32'h0002_0000);
        ack_next();
        post(3);
        idle(5);
        check(status_wr == 1'b0, "R3 pending discarded", 32'(status_wr), 32'd0);
        post(1);
        idle(3);
        check(status_word[10:4] == 7'd4, "R3 R5 report after release",
              32'(status_word[10:4]), 32'd4);
        idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule